// File: doc/BRIEF.md
# Dual-Channel ATA Register Address Decoder

This block turns a host bus access (address, address space, read or write) into a channel number and an internal register index for a two-channel ATA disk controller. It holds five programmable windows: a command block and a control block for each channel, and one shared DMA block whose two 4-byte halves serve channel 0 and channel 1. Some byte addresses name one register when read and a different one when written, so the read/write direction takes part in the decode. An access that lands in no window is reported as a bus error. The registers themselves sit elsewhere; this block only says which one an access means.

Window bases and address spaces are programmed one at a time through a small configuration port that also carries the window's size. A size that does not suit the window's kind is refused: the window stays disabled and a configuration-error flag rises. An access strobe is decoded combinationally and the result is registered, so it appears on the response outputs one clock later. A three-state machine holds the response kind: `DS_IDLE` (no response), `DS_HIT` (a window matched) and `DS_MISS` (bus error). On every clock it goes to `DS_HIT` when a strobe matches a window, to `DS_MISS` when a strobe matches none, and back to `DS_IDLE` when there is no strobe. All three states can be entered from each other.

Top module: `ata_addr_decoder`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit`, `rsp_buserr` and `cfg_err` are low and every window is disabled, so any access gives a bus error.
- R2: A strobe on `acc_valid` gives `rsp_valid` high in the next cycle only, and exactly one of `rsp_hit` and `rsp_buserr` is high with it. With no strobe all three are low.
- R3: On a read, byte offset k (0 to 7) of a command window gives register index k: 0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status.
- R4: On a write to a command window, offset 1 gives index 8 (feature) and offset 7 gives index 9 (command). The other offsets give the same index as on a read.
- R5: A control window covers exactly one byte. A read gives index 10 (alternate status), a write gives index 11 (device control), and the byte just above the window misses.
- R6: DMA window offsets 0 to 3 give channel 0 and offsets 4 to 7 give channel 1. Within each half, offset 0 to 3 gives index 12 (DMA command), 13 (spare), 14 (DMA status) and 15 (spare), on both read and write.
- R7: Window 0 (command) and window 2 (control) give channel 0. Window 1 (command) and window 3 (control) give channel 1.
- R8: When windows overlap, the match is taken from the first in the order command 0, command 1, control 0, control 1, DMA lower half, DMA upper half.
- R9: A window matches only when the access space equals the space programmed for that window.
- R10: On a bus error `rsp_chan` and `rsp_reg` read as zero.
- R11: The `cfg_sel` codes are 0 and 1 for the command windows, 2 and 3 for the control windows and 4 for DMA. The required sizes are 8, 8, 1, 1 and 8. Writing a different size disables that window and sets `cfg_err`, which stays high until that window is written again with its correct size. Codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window being configured |
| cfg_space | input | SPACE_W | Address space for the window |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | 4 | Window size in bytes |
| cfg_err | output | 1 | Some window holds a refused size |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_space | input | SPACE_W | Access address space |
| acc_addr | input | ADDR_W | Access byte address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_chan | output | 1 | Channel number |
| rsp_reg | output | 4 | Register index |
| rsp_hit | output | 1 | Access matched a window |
| rsp_buserr | output | 1 | Access matched no window |

## Verification
The assertions assume that `acc_valid` and `acc_write` are never unknown, and that an access strobe lasts one cycle per access. The read/write alias properties look at the direction of the previous cycle, so they would be confused by a direction that changes while a strobe is held. The stimulus raises each strobe on a falling edge for exactly one cycle, with the direction and address held steady. It changes configuration only between accesses, so a window never changes under an access in flight.

// File: rtl/ata_dec_pkg.sv
package ata_dec_pkg;

    localparam int NUM_WIN  = 5;
    localparam int NUM_SLOT = 6;
    localparam int REG_W    = 4;
    localparam int SIZE_W   = 4;
    localparam int SEL_W    = 3;
    localparam int SLOT_W   = 3;

    typedef enum logic [REG_W-1:0] {
        RG_DATA     = 4'd0,
        RG_ERROR    = 4'd1,
        RG_SECCNT   = 4'd2,
        RG_SECNUM   = 4'd3,
        RG_CYL_LO   = 4'd4,
        RG_CYL_HI   = 4'd5,
        RG_DEVHEAD  = 4'd6,
        RG_STATUS   = 4'd7,
        RG_FEATURE  = 4'd8,
        RG_COMMAND  = 4'd9,
        RG_ALTSTAT  = 4'd10,
        RG_DEVCTL   = 4'd11,
        RG_DMA_CMD  = 4'd12,
        RG_DMA_SP1  = 4'd13,
        RG_DMA_STAT = 4'd14,
        RG_DMA_SP3  = 4'd15
    } reg_idx_e;

    typedef enum logic [1:0] {
        WK_CMD,
        WK_CTL,
        WK_DMA
    } win_kind_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_HIT,
        DS_MISS
    } dec_state_e;

    function automatic win_kind_e kind_of_win(input int w);
        if (w < 2)      return WK_CMD;
        else if (w < 4) return WK_CTL;
        else            return WK_DMA;
    endfunction

    function automatic int size_of_kind(input win_kind_e k);
        return (k == WK_CTL) ? 1 : 8;
    endfunction

endpackage

// File: rtl/ata_win_cfg.sv
module ata_win_cfg
    import ata_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SPACE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [SPACE_W-1:0] cfg_space,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [SIZE_W-1:0]  cfg_size,
    output logic               win_vld   [NUM_WIN],
    output logic [ADDR_W-1:0]  win_base  [NUM_WIN],
    output logic [SPACE_W-1:0] win_space [NUM_WIN],
    output logic               win_bad   [NUM_WIN]
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int REQ_SIZE = size_of_kind(kind_of_win(w));
        logic sel_me;
        logic size_ok;

        assign sel_me  = cfg_we && (cfg_sel == SEL_W'(w));
        assign size_ok = (cfg_size == SIZE_W'(REQ_SIZE));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_vld[w]   <= 1'b0;
                win_bad[w]   <= 1'b0;
                win_base[w]  <= '0;
                win_space[w] <= '0;
            end else if (sel_me) begin
                win_vld[w]   <= size_ok;
                win_bad[w]   <= !size_ok;
                win_base[w]  <= cfg_base;
                win_space[w] <= cfg_space;
            end
        end
    end

endmodule

// File: rtl/ata_win_match.sv
module ata_win_match
    import ata_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SPACE_W = 2
) (
    input  logic               acc_write,
    input  logic [SPACE_W-1:0] acc_space,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               win_vld   [NUM_WIN],
    input  logic [ADDR_W-1:0]  win_base  [NUM_WIN],
    input  logic [SPACE_W-1:0] win_space [NUM_WIN],
    output logic               any_hit,
    output logic [SLOT_W-1:0]  hit_slot,
    output logic [2:0]         hit_off,
    output logic               hit_write
);

    logic              slot_hit [NUM_SLOT];
    logic [ADDR_W-1:0] slot_off [NUM_SLOT];

    // Slots 0..3 are the command and control windows, slots 4 and 5 are
    // the two halves of the DMA window.
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam int WIN  = (s < NUM_WIN) ? s : NUM_WIN - 1;
        localparam int LEN  = (s < 2) ? 8 : ((s < 4) ? 1 : 4);
        localparam int SKEW = (s == 5) ? 4 : 0;
        logic [ADDR_W-1:0] sbase;

        assign sbase         = win_base[WIN] + ADDR_W'(SKEW);
        assign slot_off[s]   = acc_addr - sbase;
        assign slot_hit[s]   = win_vld[WIN]
                             && (acc_space == win_space[WIN])
                             && (acc_addr >= sbase)
                             && (slot_off[s] < ADDR_W'(LEN));
    end

    always_comb begin
        any_hit  = 1'b0;
        hit_slot = '0;
        hit_off  = '0;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                any_hit  = 1'b1;
                hit_slot = SLOT_W'(s);
                hit_off  = slot_off[s][2:0];
            end
        end
    end

    assign hit_write = acc_write;

endmodule

// File: rtl/ata_reg_map.sv
module ata_reg_map
    import ata_dec_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        off,
    input  logic              is_write,
    output logic              chan,
    output logic [REG_W-1:0]  reg_idx
);

    reg_idx_e base_idx;

    assign chan = slot[0];

    always_comb begin
        unique case (slot)
            3'd0, 3'd1: base_idx = reg_idx_e'({1'b0, off});
            3'd2, 3'd3: base_idx = RG_ALTSTAT;
            default:    base_idx = reg_idx_e'(REG_W'(RG_DMA_CMD) + {2'b00, off[1:0]});
        endcase
    end

    always_comb begin
        reg_idx = base_idx;
        if (is_write) begin
            unique case (base_idx)
                RG_ERROR:   reg_idx = RG_FEATURE;
                RG_STATUS:  reg_idx = RG_COMMAND;
                RG_ALTSTAT: reg_idx = RG_DEVCTL;
                default:    reg_idx = base_idx;
            endcase
        end
    end

endmodule

// File: rtl/ata_addr_decoder.sv
module ata_addr_decoder
    import ata_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SPACE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [SPACE_W-1:0] cfg_space,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [3:0]         cfg_size,
    output logic               cfg_err,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [SPACE_W-1:0] acc_space,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic               rsp_valid,
    output logic               rsp_chan,
    output logic [3:0]         rsp_reg,
    output logic               rsp_hit,
    output logic               rsp_buserr
);

    logic               win_vld   [NUM_WIN];
    logic [ADDR_W-1:0]  win_base  [NUM_WIN];
    logic [SPACE_W-1:0] win_space [NUM_WIN];
    logic               win_bad   [NUM_WIN];

    logic              any_hit;
    logic [SLOT_W-1:0] hit_slot;
    logic [2:0]        hit_off;
    logic              hit_write;
    logic              map_chan;
    logic [REG_W-1:0]  map_reg;

    dec_state_e state_q, state_d;
    logic              chan_q;
    logic [REG_W-1:0]  reg_q;

    ata_win_cfg #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_space (cfg_space),
        .cfg_base  (cfg_base),
        .cfg_size  (cfg_size),
        .win_vld   (win_vld),
        .win_base  (win_base),
        .win_space (win_space),
        .win_bad   (win_bad)
    );

    ata_win_match #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_match (
        .acc_write (acc_write),
        .acc_space (acc_space),
        .acc_addr  (acc_addr),
        .win_vld   (win_vld),
        .win_base  (win_base),
        .win_space (win_space),
        .any_hit   (any_hit),
        .hit_slot  (hit_slot),
        .hit_off   (hit_off),
        .hit_write (hit_write)
    );

    ata_reg_map u_map (
        .slot     (hit_slot),
        .off      (hit_off),
        .is_write (hit_write),
        .chan     (map_chan),
        .reg_idx  (map_reg)
    );

    always_comb begin
        cfg_err = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            cfg_err = cfg_err | win_bad[w];
        end
    end

    // Next-state choice.
    always_comb begin
        unique case (state_q)
            DS_IDLE, DS_HIT, DS_MISS: begin
                if (!acc_valid)   state_d = DS_IDLE;
                else if (any_hit) state_d = DS_HIT;
                else              state_d = DS_MISS;
            end
            default: state_d = DS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    // Registered decode result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= 1'b0;
            reg_q  <= '0;
        end else if (state_d == DS_HIT) begin
            chan_q <= map_chan;
            reg_q  <= map_reg;
        end else begin
            chan_q <= 1'b0;
            reg_q  <= '0;
        end
    end

    assign rsp_valid  = (state_q != DS_IDLE);
    assign rsp_hit    = (state_q == DS_HIT);
    assign rsp_buserr = (state_q == DS_MISS);
    assign rsp_chan   = chan_q;
    assign rsp_reg    = reg_q;

endmodule

// File: rtl/ata_addr_decoder_chk.sv
module ata_addr_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       rsp_valid,
    input logic       rsp_chan,
    input logic [3:0] rsp_reg,
    input logic       rsp_hit,
    input logic       rsp_buserr
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RSP_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(acc_valid)));                       // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_buserr));                              // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_buserr));                           // R2

    AST_WRITE_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_hit && $past(acc_write))
            |-> !(rsp_reg inside {4'd1, 4'd7, 4'd10}));                      // R4

    AST_READ_NO_WRITEONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_hit && !$past(acc_write))
            |-> !(rsp_reg inside {4'd8, 4'd9, 4'd11}));                      // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_buserr |-> (!rsp_chan && rsp_reg == 4'd0));                      // R10

endmodule

bind ata_addr_decoder ata_addr_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .rsp_valid  (rsp_valid),
    .rsp_chan   (rsp_chan),
    .rsp_reg    (rsp_reg),
    .rsp_hit    (rsp_hit),
    .rsp_buserr (rsp_buserr)
);

// File: tb/test_ata_addr_decoder.sv
module test_ata_addr_decoder;

    localparam int ADDR_W  = 16;
    localparam int SPACE_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_sel = '0;
    logic [SPACE_W-1:0] cfg_space = '0;
    logic [ADDR_W-1:0]  cfg_base = '0;
    logic [3:0]         cfg_size = '0;
    logic               cfg_err;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic [SPACE_W-1:0] acc_space = '0;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic               rsp_valid;
    logic               rsp_chan;
    logic [3:0]         rsp_reg;
    logic               rsp_hit;
    logic               rsp_buserr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ata_addr_decoder #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) i_ata_addr_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_space(cfg_space),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_err(cfg_err),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_space(acc_space),
        .acc_addr(acc_addr), .rsp_valid(rsp_valid), .rsp_chan(rsp_chan),
        .rsp_reg(rsp_reg), .rsp_hit(rsp_hit), .rsp_buserr(rsp_buserr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int sel, input int sp, input int base, input int size);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_space = SPACE_W'(sp);
        cfg_base = ADDR_W'(base); cfg_size = 4'(size);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One-cycle strobe; outputs sampled on the falling edge after capture.
    task automatic access(input bit wr, input int sp, input int addr);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr;
        acc_space = SPACE_W'(sp); acc_addr = ADDR_W'(addr);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input bit wr, input int sp,
                              input int addr, input int ch, input int rg);
        access(wr, sp, addr);
        chk({tag, " valid"}, int'(rsp_valid), 1);
        chk({tag, " hit"},   int'(rsp_hit), 1);
        chk({tag, " chan"},  int'(rsp_chan), ch);
        chk({tag, " reg"},   int'(rsp_reg), rg);
    endtask

    task automatic expect_miss(input string tag, input bit wr, input int sp, input int addr);
        access(wr, sp, addr);
        chk({tag, " buserr"}, int'(rsp_buserr), 1);
        chk({tag, " hit"},    int'(rsp_hit), 0);
        chk({tag, " R10 chan"}, int'(rsp_chan), 0);
        chk({tag, " R10 reg"},  int'(rsp_reg), 0);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_hit", int'(rsp_hit), 0);
        chk("R1 rsp_buserr", int'(rsp_buserr), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        expect_miss("R1 unconfigured", 1'b0, 1, 'h1F0);
    endtask

    task automatic t_setup;
        cfg(0, 1, 'h1F0, 8);
        cfg(1, 1, 'h170, 8);
        cfg(2, 1, 'h3F6, 1);
        cfg(3, 1, 'h376, 1);
        cfg(4, 1, 'h200, 8);
        chk("R11 good sizes", int'(cfg_err), 0);
    endtask

    task automatic t_timing;
        access(1'b0, 1, 'h1F2);
        chk("R2 valid next cycle", int'(rsp_valid), 1);
        @(negedge clk);
        chk("R2 single cycle", int'(rsp_valid), 0);
        chk("R2 hit low idle", int'(rsp_hit), 0);
    endtask

    task automatic t_cmd_read;
        for (int k = 0; k < 8; k++) begin
            expect_hit("R3 ch0 read", 1'b0, 1, 'h1F0 + k, 0, k);
        end
        expect_hit("R3 ch1 read", 1'b0, 1, 'h177, 1, 7);
    endtask

    task automatic t_cmd_write;
        expect_hit("R4 err->feature", 1'b1, 1, 'h1F1, 0, 8);
        expect_hit("R4 status->command", 1'b1, 1, 'h177, 1, 9);
        expect_hit("R4 data unchanged", 1'b1, 1, 'h1F0, 0, 0);
        expect_hit("R4 devhead unchanged", 1'b1, 1, 'h176, 1, 6);
    endtask

    task automatic t_control;
        expect_hit("R5 alt read", 1'b0, 1, 'h3F6, 0, 10);
        expect_hit("R5 devctl write", 1'b1, 1, 'h376, 1, 11);
        expect_miss("R5 byte above", 1'b0, 1, 'h3F7);
    endtask

    task automatic t_dma;
        for (int k = 0; k < 8; k++) begin
            expect_hit("R6 dma read", 1'b0, 1, 'h200 + k, k / 4, 12 + (k % 4));
        end
        expect_hit("R6 dma write", 1'b1, 1, 'h205, 1, 13);
        expect_miss("R6 past dma", 1'b0, 1, 'h208);
    endtask

    task automatic t_channel;
        expect_hit("R7 window0", 1'b0, 1, 'h1F4, 0, 4);
        expect_hit("R7 window1", 1'b0, 1, 'h174, 1, 4);
        expect_hit("R7 window2", 1'b0, 1, 'h3F6, 0, 10);
        expect_hit("R7 window3", 1'b0, 1, 'h376, 1, 10);
    endtask

    task automatic t_priority;
        cfg(1, 1, 'h1F0, 8);
        expect_hit("R8 cmd0 over cmd1", 1'b0, 1, 'h1F3, 0, 3);
        cfg(2, 1, 'h1F5, 1);
        expect_hit("R8 cmd0 over ctl0", 1'b0, 1, 'h1F5, 0, 5);
        cfg(4, 1, 'h376, 8);
        expect_hit("R8 ctl1 over dma", 1'b0, 1, 'h376, 1, 10);
        cfg(1, 1, 'h170, 8);
        cfg(2, 1, 'h3F6, 1);
        cfg(4, 1, 'h200, 8);
    endtask

    task automatic t_space;
        expect_miss("R9 wrong space", 1'b0, 2, 'h1F0);
        expect_miss("R9 space zero", 1'b1, 0, 'h203);
        expect_miss("R10 unmapped", 1'b0, 1, 'h1000);
    endtask

    task automatic t_cfg_err;
        cfg(2, 1, 'h3F6, 8);
        chk("R11 bad ctl size", int'(cfg_err), 1);
        expect_miss("R11 bad window off", 1'b0, 1, 'h3F6);
        cfg(2, 1, 'h3F6, 1);
        chk("R11 cleared", int'(cfg_err), 0);
        expect_hit("R11 window back", 1'b0, 1, 'h3F6, 0, 10);
        cfg(0, 1, 'h1F0, 4);
        chk("R11 bad cmd size", int'(cfg_err), 1);
        cfg(0, 1, 'h1F0, 8);
        chk("R11 cmd cleared", int'(cfg_err), 0);
        cfg(6, 1, 'h1000, 3);
        chk("R11 sel 6 ignored err", int'(cfg_err), 0);
        expect_miss("R11 sel 6 ignored map", 1'b0, 1, 'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_timing();
        t_cmd_read();
        t_cmd_write();
        t_control();
        t_dma();
        t_channel();
        t_priority();
        t_space();
        t_cfg_err();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule